// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared broadcast bus. Each line holds one data word, an address tag and a coherence state: Modified, Exclusive, Shared or Invalid. Local processor reads and writes are served from the array when the line's state allows it. Otherwise the controller takes the bus and runs a read, a read-for-ownership, an upgrade or a write-back. Memory is updated only when dirty data leaves the cache, which happens either by eviction or by supplying it to a peer.

The controller also watches every transaction that the other caches put on the bus. In the same cycle it answers with a shared indication, or with a dirty indication and the line's data. On the next clock edge it downgrades or invalidates its own copy. While a miss or an upgrade is in progress, the processor port holds its ready signal low. A response strobe marks the completion of every access.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, `bus_req` is low and no snooped address gets a shared or dirty answer.
- R2: A read that hits a valid line returns the stored word with `cpu_resp_valid` one clock after acceptance and issues no bus transaction.
- R3: A read miss issues bus command 0 (read) for the requested address and returns `bus_rdata`. The line is installed Exclusive when `bus_shared_in` is low at completion and Shared when it is high.
- R4: A write to a line held Exclusive or Modified completes one clock after acceptance with no bus transaction and leaves the line Modified.
- R5: A write to a line held Shared first issues bus command 2 (upgrade) for that address. The line then becomes Modified with the new word.
- R6: A write miss issues bus command 1 (read-exclusive) for the address and installs the line as Modified with the written word.
- R7: A miss that displaces a Modified line first issues bus command 3 (write-back) carrying the victim's address and data, then the fill command. A miss that displaces a clean line issues only the fill command.
- R8: A snooped read (command 0) to a line held Modified raises `snp_dirty` and `snp_shared` in the same cycle with the line's word on `snp_data`, and the line becomes Shared.
- R9: A snooped read to a line held Exclusive or Shared raises `snp_shared` only, and an Exclusive line becomes Shared.
- R10: A snooped read-exclusive (1) or upgrade (2) to a held line makes it Invalid. A read-exclusive that hits a Modified line also raises `snp_dirty` with the line's word.
- R11: A snooped write-back (3), or any snoop whose tag does not match the indexed line, gets no answer and changes no state.
- R12: `cpu_ready` is low from acceptance of an access until its response, and `cpu_resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor access request, held until response |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_resp_valid | output | 1 | One-cycle completion strobe |
| cpu_resp_rdata | output | DATA_W | Read data, or the stored word for writes |
| bus_req | output | 1 | Bus ownership request |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Current transaction completes at this edge |
| bus_rdata | input | DATA_W | Fill data |
| bus_shared_in | input | 1 | Some peer holds the line being read |
| snp_valid | input | 1 | Peer transaction present on the bus |
| snp_cmd | input | 2 | Peer command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Peer address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_dirty | output | 1 | This cache supplies modified data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The first clock edge after acceptance registers a hit response. The bench therefore samples `cpu_resp_valid` at the next falling edge and requires a latency of exactly one. A miss completes at the edge where `bus_gnt` and `bus_done` are both high, and its response appears one cycle later. The bench waits on the strobe and then checks the bus transactions it logged against the expected command order. Snoop answers are combinational, so they are sampled a moment after the snoop inputs are driven. Any state change a snoop causes is verified through later accesses: a write that needs an upgrade proves a downgrade, and a new bus read proves an invalidation.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_UPG = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_t;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_BUS  = 1'b1
    } fsm_state_t;

    // State a held line takes after a peer transaction is observed.
    function automatic line_state_t snoop_next(line_state_t cur, bus_cmd_t cmd);
        case (cmd)
            BC_RD:          return (cur == ST_I) ? ST_I : ST_S;
            BC_RDX, BC_UPG: return ST_I;
            default:        return cur;
        endcase
    endfunction

    // State installed when one of this cache's own transactions completes.
    function automatic line_state_t fill_result(bus_cmd_t cmd, logic shared);
        case (cmd)
            BC_RD:          return shared ? ST_S : ST_E;
            BC_RDX, BC_UPG: return ST_M;
            default:        return ST_I;
        endcase
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fill_we,
    input  logic [IDX_W-1:0]              fill_idx,
    input  line_state_t                   fill_state,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [DATA_W-1:0]             fill_data,
    input  logic                          snp_we,
    input  logic [IDX_W-1:0]              snp_idx,
    input  line_state_t                   snp_state,
    input  logic [IDX_W-1:0]              a_idx,
    output line_state_t                   a_state,
    output logic [TAG_W-1:0]              a_tag,
    output logic [DATA_W-1:0]             a_data,
    input  logic [IDX_W-1:0]              b_idx,
    output line_state_t                   b_state,
    output logic [TAG_W-1:0]              b_tag,
    output logic [DATA_W-1:0]             b_data,
    output line_state_t [LINES-1:0]       st_all
);

    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_t       st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r   <= ST_I;
                tag_r  <= '0;
                data_r <= '0;
            end else if (fill_we && fill_idx == IDX_W'(g)) begin
                st_r   <= fill_state;
                tag_r  <= fill_tag;
                data_r <= fill_data;
            end else if (snp_we && snp_idx == IDX_W'(g)) begin
                st_r   <= snp_state;
            end
        end

        assign st_all[g] = st_r;
        assign tag_q[g]  = tag_r;
        assign data_q[g] = data_r;
    end

    assign a_state = st_all[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_all[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

    // Own updates and peer updates never meet on one line in one cycle.
    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> !(snp_we && snp_idx == fill_idx)); // R10

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                snp_valid,
    input  bus_cmd_t            snp_cmd,
    input  logic [ADDR_W-1:0]   snp_addr,
    output logic [IDX_W-1:0]    look_idx,
    input  line_state_t         look_state,
    input  logic [TAG_W-1:0]    look_tag,
    input  logic [DATA_W-1:0]   look_data,
    output logic                snp_shared,
    output logic                snp_dirty,
    output logic [DATA_W-1:0]   snp_data,
    output logic                upd_we,
    output line_state_t         upd_state
);

    logic held;

    assign look_idx   = snp_addr[IDX_W-1:0];
    assign held       = snp_valid && look_state != ST_I
                        && look_tag == snp_addr[ADDR_W-1:IDX_W];

    assign snp_shared = held && snp_cmd == BC_RD;
    assign snp_dirty  = held && look_state == ST_M
                        && (snp_cmd == BC_RD || snp_cmd == BC_RDX);
    assign snp_data   = snp_dirty ? look_data : '0;
    assign upd_we     = held && snp_cmd != BC_WB;
    assign upd_state  = snoop_next(look_state, snp_cmd);

    AST_WB_SILENT: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == BC_WB) |-> !snp_shared && !snp_dirty); // R11

    AST_DIRTY_IMPLIES_HELD: assert property (@(posedge clk) disable iff (rst)
        snp_dirty |-> snp_valid && snp_cmd != BC_UPG); // R8

endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_req_valid,
    input  logic                cpu_req_write,
    input  logic [ADDR_W-1:0]   cpu_req_addr,
    input  logic [DATA_W-1:0]   cpu_req_wdata,
    output logic                cpu_ready,
    output logic                cpu_resp_valid,
    output logic [DATA_W-1:0]   cpu_resp_rdata,
    input  logic                snoop_busy,
    output logic                bus_req,
    output bus_cmd_t            bus_cmd,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_gnt,
    input  logic                bus_done,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_shared_in,
    output logic [IDX_W-1:0]    lk_idx,
    input  line_state_t         lk_state,
    input  logic [TAG_W-1:0]    lk_tag,
    input  logic [DATA_W-1:0]   lk_data,
    output logic                fill_we,
    output logic [IDX_W-1:0]    fill_idx,
    output line_state_t         fill_state,
    output logic [TAG_W-1:0]    fill_tag,
    output logic [DATA_W-1:0]   fill_data
);

    fsm_state_t        fs_q;
    logic [ADDR_W-1:0] hold_addr;
    logic              hold_write;
    logic [DATA_W-1:0] hold_wdata;
    logic              resp_q;
    logic [DATA_W-1:0] rdata_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit, victim_dirty, accept, local_ok, xfer;

    assign cur_addr     = (fs_q == FS_IDLE) ? cpu_req_addr : hold_addr;
    assign lk_idx       = cur_addr[IDX_W-1:0];
    assign cur_tag      = cur_addr[ADDR_W-1:IDX_W];
    assign hit          = lk_state != ST_I && lk_tag == cur_tag;
    assign victim_dirty = lk_state == ST_M && lk_tag != cur_tag;

    assign cpu_ready    = fs_q == FS_IDLE && !resp_q && !snoop_busy;
    assign accept       = cpu_ready && cpu_req_valid;
    assign local_ok     = accept && hit
                          && (!cpu_req_write || lk_state inside {ST_E, ST_M});

    // Command chosen from the live line state, so a snoop that lands
    // while the request waits for the bus is taken into account.
    always_comb begin
        if (victim_dirty)    bus_cmd = BC_WB;
        else if (hold_write) bus_cmd = (hit && lk_state == ST_S) ? BC_UPG : BC_RDX;
        else                 bus_cmd = BC_RD;
    end

    assign bus_req   = fs_q == FS_BUS;
    assign bus_addr  = victim_dirty ? {lk_tag, lk_idx} : hold_addr;
    assign bus_wdata = lk_data;
    assign xfer      = bus_req && bus_gnt && bus_done;

    always_comb begin
        fill_we    = 1'b0;
        fill_idx   = lk_idx;
        fill_state = ST_I;
        fill_tag   = cur_tag;
        fill_data  = lk_data;
        if (local_ok && cpu_req_write) begin
            fill_we    = 1'b1;
            fill_state = ST_M;
            fill_data  = cpu_req_wdata;
        end else if (xfer) begin
            fill_we = 1'b1;
            if (bus_cmd == BC_WB) begin
                fill_state = ST_I;
                fill_tag   = lk_tag;
            end else begin
                fill_state = fill_result(bus_cmd, bus_shared_in);
                fill_data  = hold_write ? hold_wdata : bus_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q       <= FS_IDLE;
            hold_addr  <= '0;
            hold_write <= 1'b0;
            hold_wdata <= '0;
            resp_q     <= 1'b0;
            rdata_q    <= '0;
        end else begin
            resp_q <= 1'b0;
            case (fs_q)
                FS_IDLE: begin
                    if (local_ok) begin
                        resp_q  <= 1'b1;
                        rdata_q <= cpu_req_write ? cpu_req_wdata : lk_data;
                    end else if (accept) begin
                        hold_addr  <= cpu_req_addr;
                        hold_write <= cpu_req_write;
                        hold_wdata <= cpu_req_wdata;
                        fs_q       <= FS_BUS;
                    end
                end
                FS_BUS: begin
                    if (xfer && bus_cmd != BC_WB) begin
                        resp_q  <= 1'b1;
                        rdata_q <= hold_write ? hold_wdata : bus_rdata;
                        fs_q    <= FS_IDLE;
                    end
                end
                default: fs_q <= FS_IDLE;
            endcase
        end
    end

    assign cpu_resp_valid = resp_q;
    assign cpu_resp_rdata = rdata_q;

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |=> !cpu_resp_valid); // R12

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cpu_ready); // R12

    AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (xfer && bus_cmd != BC_WB) |=> cpu_resp_valid); // R3

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (xfer && bus_cmd == BC_WB) |=> bus_req && bus_cmd != BC_WB); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !xfer) |=> bus_req); // R12

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req_valid,
    input  logic               cpu_req_write,
    input  logic [ADDR_W-1:0]  cpu_req_addr,
    input  logic [DATA_W-1:0]  cpu_req_wdata,
    output logic               cpu_ready,
    output logic               cpu_resp_valid,
    output logic [DATA_W-1:0]  cpu_resp_rdata,
    output logic               bus_req,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_gnt,
    input  logic               bus_done,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_shared_in,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [ADDR_W-1:0]  snp_addr,
    output logic               snp_shared,
    output logic               snp_dirty,
    output logic [DATA_W-1:0]  snp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    bus_cmd_t                 cmd_e;
    bus_cmd_t                 snp_cmd_e;
    logic [IDX_W-1:0]         a_idx, b_idx, fill_idx;
    line_state_t              a_state, b_state, fill_state, upd_state;
    logic [TAG_W-1:0]         a_tag, b_tag, fill_tag;
    logic [DATA_W-1:0]        a_data, b_data, fill_data;
    logic                     fill_we, upd_we;
    line_state_t [LINES-1:0]  st_all;

    assign snp_cmd_e = bus_cmd_t'(snp_cmd);
    assign bus_cmd   = cmd_e;

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .fill_we    (fill_we),
        .fill_idx   (fill_idx),
        .fill_state (fill_state),
        .fill_tag   (fill_tag),
        .fill_data  (fill_data),
        .snp_we     (upd_we),
        .snp_idx    (b_idx),
        .snp_state  (upd_state),
        .a_idx      (a_idx),
        .a_state    (a_state),
        .a_tag      (a_tag),
        .a_data     (a_data),
        .b_idx      (b_idx),
        .b_state    (b_state),
        .b_tag      (b_tag),
        .b_data     (b_data),
        .st_all     (st_all)
    );

    mesi_snoop_resp #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_snoop (
        .clk        (clk),
        .rst        (rst),
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd_e),
        .snp_addr   (snp_addr),
        .look_idx   (b_idx),
        .look_state (b_state),
        .look_tag   (b_tag),
        .look_data  (b_data),
        .snp_shared (snp_shared),
        .snp_dirty  (snp_dirty),
        .snp_data   (snp_data),
        .upd_we     (upd_we),
        .upd_state  (upd_state)
    );

    mesi_ctrl_fsm #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_ready      (cpu_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .snoop_busy     (snp_valid),
        .bus_req        (bus_req),
        .bus_cmd        (cmd_e),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_gnt        (bus_gnt),
        .bus_done       (bus_done),
        .bus_rdata      (bus_rdata),
        .bus_shared_in  (bus_shared_in),
        .lk_idx         (a_idx),
        .lk_state       (a_state),
        .lk_tag         (a_tag),
        .lk_data        (a_data),
        .fill_we        (fill_we),
        .fill_idx       (fill_idx),
        .fill_state     (fill_state),
        .fill_tag       (fill_tag),
        .fill_data      (fill_data)
    );

    AST_SNOOP_READ_DOWNGRADES: assert property (@(posedge clk) disable iff (rst)
        (upd_we && snp_cmd_e == BC_RD) |=> st_all[$past(b_idx)] == ST_S); // R9

    AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (rst)
        (upd_we && snp_cmd_e != BC_RD) |=> st_all[$past(b_idx)] == ST_I); // R10

    AST_DIRTY_LEAVES_M: assert property (@(posedge clk) disable iff (rst)
        snp_dirty |=> st_all[$past(b_idx)] != ST_M); // R8

endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
    import mesi_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_ready, cpu_resp_valid;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt = 1'b0, bus_done = 1'b0, bus_shared_in = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_dirty;
    logic [DW-1:0] snp_data;

    logic [DW-1:0] mem [256];
    logic          peer_shared = 1'b0;
    logic [1:0]    log_cmd  [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            n_log = 0;
    int            n_checks = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_mesi_snoop_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_data(snp_data)
    );

    // Behavioural bus: grant, then complete one cycle later, logging each transfer.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = DW'(16'hA000 + i);
        forever begin
            @(negedge clk);
            if (bus_done) begin
                bus_done = 1'b0;
                bus_gnt  = 1'b0;
            end else if (bus_gnt) begin
                if (n_log < 64) begin
                    log_cmd[n_log]  = bus_cmd;
                    log_addr[n_log] = bus_addr;
                    log_data[n_log] = bus_wdata;
                end
                n_log++;
                if (bus_cmd == BC_WB) mem[bus_addr] = bus_wdata;
                bus_rdata     = mem[bus_addr];
                bus_shared_in = peer_shared;
                bus_done      = 1'b1;
            end else if (bus_req) begin
                bus_gnt = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat, output bit rdy_ok);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        lat = 0;
        rdy_ok = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            if (cpu_ready) rdy_ok = 1'b0;
        end while (!cpu_resp_valid);
        rd = cpu_resp_rdata;
        cpu_req_valid = 1'b0;
        @(negedge clk);
        if (cpu_resp_valid) rdy_ok = 1'b0;
    endtask

    task automatic snoop(input bus_cmd_t c, input logic [AW-1:0] a,
                         output bit sh, output bit dy, output logic [DW-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = c;
        snp_addr  = a;
        #1;
        sh = snp_shared;
        dy = snp_dirty;
        d  = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
        if (dy) mem[a] = d;
    endtask

    task automatic t_reset();
        bit sh, dy; logic [DW-1:0] d;
        check(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
        check(bus_req == 1'b0, "R1", "bus_req after reset", int'(bus_req), 0);
        snoop(BC_RD, 8'h11, sh, dy, d);
        check(!sh && !dy, "R1", "snoop answer on empty cache", int'({sh, dy}), 0);
    endtask

    task automatic t_exclusive_path();
        logic [DW-1:0] rd; int lat; bit rk; int n0;
        bit sh, dy; logic [DW-1:0] d;
        peer_shared = 1'b0;
        n0 = n_log;
        cpu_op(1'b0, 8'h11, '0, rd, lat, rk);
        check(rd == 16'hA011, "R3", "read miss data", int'(rd), 'hA011);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_RD && log_addr[n0] == 8'h11,
              "R3", "read miss command", int'(log_cmd[n0]), int'(BC_RD));
        check(rk, "R12", "ready low while busy", 0, 1);
        n0 = n_log;
        cpu_op(1'b0, 8'h11, '0, rd, lat, rk);
        check(lat == 1 && n_log == n0, "R2", "read hit latency", lat, 1);
        check(rd == 16'hA011, "R2", "read hit data", int'(rd), 'hA011);
        n0 = n_log;
        cpu_op(1'b1, 8'h11, 16'h1111, rd, lat, rk);
        check(lat == 1 && n_log == n0, "R4", "silent write on Exclusive", n_log - n0, 0);
        snoop(BC_RD, 8'h11, sh, dy, d);
        check(sh && dy && d == 16'h1111, "R8", "dirty intervention data", int'(d), 'h1111);
        n0 = n_log;
        cpu_op(1'b1, 8'h11, 16'h2222, rd, lat, rk);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_UPG && log_addr[n0] == 8'h11,
              "R5", "upgrade after downgrade", int'(log_cmd[n0]), int'(BC_UPG));
        snoop(BC_RDX, 8'h11, sh, dy, d);
        check(dy && d == 16'h2222, "R10", "read-exclusive takes dirty data", int'(d), 'h2222);
        n0 = n_log;
        cpu_op(1'b0, 8'h11, '0, rd, lat, rk);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_RD, "R10", "invalidated line refetched",
              n_log - n0, 1);
        check(rd == 16'h2222, "R10", "refetch sees flushed data", int'(rd), 'h2222);
        snoop(BC_RD, 8'h11, sh, dy, d);
        check(sh && !dy, "R9", "snoop read on Exclusive", int'({sh, dy}), 2);
        n0 = n_log;
        cpu_op(1'b1, 8'h11, 16'h2323, rd, lat, rk);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_UPG, "R9", "Exclusive became Shared",
              int'(log_cmd[n0]), int'(BC_UPG));
    endtask

    task automatic t_shared_fill();
        logic [DW-1:0] rd; int lat; bit rk; int n0;
        bit sh, dy; logic [DW-1:0] d;
        peer_shared = 1'b1;
        cpu_op(1'b0, 8'h22, '0, rd, lat, rk);
        peer_shared = 1'b0;
        check(rd == 16'hA022, "R3", "shared fill data", int'(rd), 'hA022);
        snoop(BC_RD, 8'h22, sh, dy, d);
        check(sh && !dy, "R9", "snoop read on Shared", int'({sh, dy}), 2);
        n0 = n_log;
        cpu_op(1'b1, 8'h22, 16'h3333, rd, lat, rk);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_UPG, "R3", "shared install needs upgrade",
              int'(log_cmd[n0]), int'(BC_UPG));
        snoop(BC_RD, 8'h22, sh, dy, d);
        check(dy && d == 16'h3333, "R8", "upgraded line supplies data", int'(d), 'h3333);
        snoop(BC_UPG, 8'h22, sh, dy, d);
        check(!dy && !sh, "R10", "upgrade snoop answer", int'({sh, dy}), 0);
        n0 = n_log;
        cpu_op(1'b0, 8'h22, '0, rd, lat, rk);
        check(n_log - n0 == 1 && rd == 16'h3333, "R10", "upgrade snoop invalidated",
              int'(rd), 'h3333);
    endtask

    task automatic t_write_miss_and_evict();
        logic [DW-1:0] rd; int lat; bit rk; int n0;
        bit sh, dy; logic [DW-1:0] d;
        n0 = n_log;
        cpu_op(1'b1, 8'h33, 16'h4444, rd, lat, rk);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_RDX && log_addr[n0] == 8'h33,
              "R6", "write miss command", int'(log_cmd[n0]), int'(BC_RDX));
        snoop(BC_RD, 8'h33, sh, dy, d);
        check(dy && d == 16'h4444, "R6", "write miss installs Modified", int'(d), 'h4444);
        n0 = n_log;
        cpu_op(1'b1, 8'h37, 16'h5555, rd, lat, rk);
        check(n_log - n0 == 1 && log_cmd[n0] == BC_RDX, "R7", "clean eviction no write-back",
              n_log - n0, 1);
        n0 = n_log;
        cpu_op(1'b0, 8'h3B, '0, rd, lat, rk);
        check(n_log - n0 == 2 && log_cmd[n0] == BC_WB && log_addr[n0] == 8'h37
              && log_data[n0] == 16'h5555, "R7", "dirty victim written back first",
              int'(log_cmd[n0]), int'(BC_WB));
        check(log_cmd[n0+1] == BC_RD && log_addr[n0+1] == 8'h3B && rd == 16'hA03B,
              "R7", "fill after write-back", int'(rd), 'hA03B);
        check(mem[8'h37] == 16'h5555, "R7", "memory holds victim", int'(mem[8'h37]), 'h5555);
    endtask

    task automatic t_ignored();
        logic [DW-1:0] rd; int lat; bit rk; int n0;
        bit sh, dy; logic [DW-1:0] d;
        snoop(BC_RDX, 8'h7F, sh, dy, d);
        check(!sh && !dy, "R11", "tag mismatch answer", int'({sh, dy}), 0);
        snoop(BC_WB, 8'h3B, sh, dy, d);
        check(!sh && !dy, "R11", "write-back snoop answer", int'({sh, dy}), 0);
        n0 = n_log;
        cpu_op(1'b1, 8'h3B, 16'h6666, rd, lat, rk);
        check(lat == 1 && n_log == n0, "R11", "line kept Exclusive", n_log - n0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exclusive_path();
        t_shared_fill();
        t_write_miss_and_evict();
        t_ignored();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule